// File: doc/BRIEF.md
# Fault-Injectable Register and Gate Cell Bank

This block stands in for a row of ordinary storage cells and simple combinational gates. Fault injection can be controlled from outside. Each of the N positions holds one flip-flop and one two-input gate. A parameter chooses the gate function, and a second parameter chooses which flip-flops have a clock enable. When no fault is requested, the flip-flops load and hold as plain cells would, and each gate output is the plain gate function of its two inputs.

A fault campaign drives a per-cell select vector, a per-cell mask vector, a fault kind code and a pulse length. The kind code picks one of three faults:

- An upset inverts the stored bit of a flip-flop.
- A transient inverts a gate output for a programmed number of cycles and then releases it.
- A stuck-at forces a gate output to the mask bit for as long as the select stays high.

A region code can narrow the selects to the lower half of the bank or to the upper half. This lets a campaign aim at one half without rewriting the select vector.

Top module: `fault_cell_bank`

## Requirements
- R1: While rst_n is low, every bit of q is 0 and no transient pulse is active.
- R2: With no fault in effect, a cell without enable loads d[i] at each rising edge. A cell listed in EN_CELLS loads d[i] only when en[i] is 1 and otherwise holds. comb_y[i] equals the gate function of comb_a[i] and comb_b[i] (GATE 0 = AND, 1 = OR, 2 = XOR).
- R3: When fault_kind is 2'b01 and cell i is effectively selected, q[i] becomes the inverse of its previous stored value at that edge, whatever en[i] and d[i] are. The inverted value stays until the cell loads again.
- R4: When fault_kind is 2'b10, cell i is effectively selected, its pulse is idle and pulse_len is L > 0, comb_y[i] is the inverted gate value for exactly the L cycles that follow that edge. It then returns to the plain gate value.
- R5: A transient select on a cell whose pulse is still running neither restarts nor lengthens that pulse.
- R6: A transient request with pulse_len equal to 0 leaves comb_y unchanged.
- R7: When fault_kind is 2'b11 and cell i is effectively selected, comb_y[i] equals inj_mask[i] in the same cycle. It returns to the plain value as soon as the select drops.
- R8: The effective select is inj_sel ANDed with a region mask, where half_sel 2'b00 gives all cells, 2'b01 gives cells 0..N/2-1, 2'b10 gives cells N/2..N-1, and 2'b11 gives no cells.
- R9: fault_kind 2'b00 makes inj_sel have no effect on q or comb_y.
- R10: An upset and a load on the same edge give the inverse of the old stored value, not the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| d | input | N | Flip-flop data inputs |
| en | input | N | Clock enables, used only by cells listed in EN_CELLS |
| q | output | N | Flip-flop outputs |
| comb_a | input | N | First gate input of each cell |
| comb_b | input | N | Second gate input of each cell |
| comb_y | output | N | Gate outputs after fault insertion |
| inj_sel | input | N | Per-cell injection select |
| inj_mask | input | N | Per-cell forced value for stuck-at faults |
| fault_kind | input | 2 | 00 none, 01 upset, 10 transient, 11 stuck-at |
| pulse_len | input | PW | Transient length in cycles |
| half_sel | input | 2 | Region code applied to inj_sel |

## Verification
The bench makes an upset coincide with a disabled enable and with an active load. A design that gated the flip on the enable, or let new data win, would miss the inversion or store d. It counts every cycle of a transient, retriggers it mid-pulse and requests a zero length. Off-by-one counters, pulses that restart, or a spurious one-cycle glitch would then show up on comb_y. It also sweeps all four region codes with the same select vector, which exposes a swapped or mis-sized half mask as flips in the wrong cells.

// File: rtl/fault_cell_bank.sv
module fault_cell_bank #(
  parameter int N = 8,
  parameter int PW = 4,
  parameter int GATE = 0,
  parameter logic [N-1:0] EN_CELLS = {N{1'b0}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  d,
  input  logic [N-1:0]  en,
  output logic [N-1:0]  q,
  input  logic [N-1:0]  comb_a,
  input  logic [N-1:0]  comb_b,
  output logic [N-1:0]  comb_y,
  input  logic [N-1:0]  inj_sel,
  input  logic [N-1:0]  inj_mask,
  input  logic [1:0]    fault_kind,
  input  logic [PW-1:0] pulse_len,
  input  logic [1:0]    half_sel
);
  localparam int HALF = N / 2;
  localparam logic [N-1:0] LO_MASK = {{(N-HALF){1'b0}}, {HALF{1'b1}}};
  localparam logic [N-1:0] HI_MASK = ~LO_MASK;

  logic [N-1:0] region, eff, up_hit, tr_hit, st_hit;

  assign region = (half_sel == 2'b00) ? {N{1'b1}} :
                  (half_sel == 2'b01) ? LO_MASK :
                  (half_sel == 2'b10) ? HI_MASK : {N{1'b0}};
  assign eff    = inj_sel & region;
  assign up_hit = (fault_kind == 2'b01) ? eff : {N{1'b0}};
  assign tr_hit = (fault_kind == 2'b10) ? eff : {N{1'b0}};
  assign st_hit = (fault_kind == 2'b11) ? eff : {N{1'b0}};

  for (genvar i = 0; i < N; i++) begin : g_cell
    logic          qc;
    logic          raw;
    logic [PW-1:0] cnt;

    if (GATE == 0) begin : g_and
      assign raw = comb_a[i] & comb_b[i];
    end else if (GATE == 1) begin : g_or
      assign raw = comb_a[i] | comb_b[i];
    end else begin : g_xor
      assign raw = comb_a[i] ^ comb_b[i];
    end

    if (EN_CELLS[i]) begin : g_ce
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)         qc <= 1'b0;
        else if (up_hit[i]) qc <= ~qc;
        else if (en[i])     qc <= d[i];
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)         qc <= 1'b0;
        else if (up_hit[i]) qc <= ~qc;
        else                qc <= d[i];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                             cnt <= '0;
      else if (cnt != '0)                     cnt <= cnt - 1'b1;
      else if (tr_hit[i] && pulse_len != '0)  cnt <= pulse_len;

    assign q[i]      = qc;
    assign comb_y[i] = st_hit[i] ? inj_mask[i] : (raw ^ (cnt != '0));
  end
endmodule

// File: rtl/fault_cell_bank_chk.sv
module fault_cell_bank_chk #(
  parameter int N = 8,
  parameter int PW = 4,
  parameter int GATE = 0,
  parameter logic [N-1:0] EN_CELLS = {N{1'b0}}
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  d,
  input logic [N-1:0]  en,
  input logic [N-1:0]  q,
  input logic [N-1:0]  comb_a,
  input logic [N-1:0]  comb_b,
  input logic [N-1:0]  comb_y,
  input logic [N-1:0]  inj_sel,
  input logic [N-1:0]  inj_mask,
  input logic [1:0]    fault_kind,
  input logic [PW-1:0] pulse_len,
  input logic [1:0]    half_sel
);
  localparam int HALF = N / 2;
  logic [N-1:0] zone, ups, sticks, keep_next;
  logic seen;

  always_comb begin
    zone = '0;
    for (int i = 0; i < N; i++)
      zone[i] = (half_sel == 2'b00) || (half_sel == 2'b01 && i < HALF) ||
                (half_sel == 2'b10 && i >= HALF);
  end
  assign ups       = (fault_kind == 2'b01) ? (inj_sel & zone) : '0;
  assign sticks    = (fault_kind == 2'b11) ? (inj_sel & zone) : '0;
  assign keep_next = (d & (en | ~EN_CELLS)) | (q & ~en & EN_CELLS);

  initial seen = 1'b0;
  always @(posedge clk) seen <= 1'b1;

  // R1
  always @(negedge clk)
    if (seen && !rst_n) a_r1_reset_clear: assert (q == '0);

  a_r2_plain_load: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ $past(keep_next)) & ~$past(ups)) == '0));

  a_r3_upset_flip: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q ^ ~$past(q)) & $past(ups)) == '0));

  a_r7_stuck_value: assert property (@(posedge clk) disable iff (!rst_n)
    ((comb_y ^ inj_mask) & sticks) == '0);
endmodule

bind fault_cell_bank fault_cell_bank_chk #(.N(N), .PW(PW), .GATE(GATE), .EN_CELLS(EN_CELLS)) u_chk (.*);

// File: tb/sim_fault_cell_bank.sv
`timescale 1ns/1ps
module sim_fault_cell_bank;
  localparam int N = 8;
  localparam int PW = 4;
  localparam logic [N-1:0] ENC = 8'hF0;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] d = 0, en = 0, a = 0, b = 0, sel = 0, mask = 0, q, y;
  logic [1:0] kind = 0, half = 0;
  logic [PW-1:0] plen = 0;
  int checks = 0, errors = 0;

  typedef struct { string tag; logic [N-1:0] q; logic [N-1:0] y; } item_t;
  item_t sb[$];
  logic [N-1:0] mq = 0;
  int mcnt [N];

  always #10 clk = ~clk;

  fault_cell_bank #(.N(N), .PW(PW), .GATE(0), .EN_CELLS(ENC)) u0 (
    .clk(clk), .rst_n(rst_n), .d(d), .en(en), .q(q), .comb_a(a), .comb_b(b),
    .comb_y(y), .inj_sel(sel), .inj_mask(mask), .fault_kind(kind),
    .pulse_len(plen), .half_sel(half));

  function automatic logic [N-1:0] zone_of(logic [1:0] h);
    case (h)
      2'b00: return 8'hFF;
      2'b01: return 8'h0F;
      2'b10: return 8'hF0;
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(string tag, logic rst, logic [N-1:0] td, logic [N-1:0] ten,
                      logic [N-1:0] ta, logic [N-1:0] tb2, logic [1:0] tk,
                      logic [N-1:0] ts, logic [N-1:0] tm, logic [PW-1:0] tl,
                      logic [1:0] th);
    item_t it;
    logic [N-1:0] eff, ey, nq;
    @(negedge clk); #1;
    rst_n = rst; d = td; en = ten; a = ta; b = tb2; kind = tk; sel = ts;
    mask = tm; plen = tl; half = th;
    eff = ts & zone_of(th);
    for (int i = 0; i < N; i++) begin
      ey[i] = (ta[i] & tb2[i]) ^ (mcnt[i] != 0);
      if (tk == 2'b11 && eff[i]) ey[i] = tm[i];
    end
    it.tag = tag; it.q = mq; it.y = ey;
    sb.push_back(it);
    for (int i = 0; i < N; i++) begin
      if (tk == 2'b01 && eff[i]) nq[i] = ~mq[i];
      else if (ENC[i] && !ten[i]) nq[i] = mq[i];
      else nq[i] = td[i];
      if (mcnt[i] != 0) mcnt[i] = mcnt[i] - 1;
      else if (tk == 2'b10 && eff[i] && tl != 0) mcnt[i] = int'(tl);
      if (!rst) mcnt[i] = 0;
    end
    mq = rst ? nq : '0;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk); #8;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        checks++;
        if (q !== it.q) begin
          errors++;
          $display("FAIL %s: q actual %h expected %h", it.tag, q, it.q);
        end
        checks++;
        if (y !== it.y) begin
          errors++;
          $display("FAIL %s: comb_y actual %h expected %h", it.tag, y, it.y);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < N; i++) mcnt[i] = 0;
    step("R1 reset", 0, 8'h3C, 8'hFF, 8'hF0, 8'hFF, 2'b00, 0, 0, 0, 0);
    step("R1 reset", 0, 8'h3C, 8'hFF, 8'hF0, 8'hFF, 2'b10, 8'hFF, 0, 3, 0);
    step("R2 load", 1, 8'hA5, 8'hFF, 8'hFF, 8'h0F, 0, 0, 0, 0, 0);
    step("R2 load", 1, 8'h5A, 8'hFF, 8'hAA, 8'hCC, 0, 0, 0, 0, 0);
    step("R2 enable hold", 1, 8'hFF, 8'h0F, 8'h00, 8'hFF, 0, 0, 0, 0, 0);
    step("R2 enable hold", 1, 8'h00, 8'h30, 8'hFF, 8'hFF, 0, 0, 0, 0, 0);
    step("R9 kind none", 1, 8'h00, 8'h00, 8'hFF, 8'hFF, 2'b00, 8'hFF, 8'hFF, 5, 0);
    step("R3 upset en low", 1, 8'h00, 8'h00, 8'hFF, 8'hFF, 2'b01, 8'h81, 0, 0, 0);
    step("R3 upset persists", 1, 8'h00, 8'h00, 8'hFF, 8'hFF, 0, 0, 0, 0, 0);
    step("R3 upset persists", 1, 8'h00, 8'h00, 8'hFF, 8'hFF, 0, 0, 0, 0, 0);
    step("R10 upset with load", 1, 8'hFF, 8'hFF, 8'h00, 8'h00, 2'b01, 8'h11, 0, 0, 0);
    step("R10 upset with load", 1, 8'h0F, 8'hFF, 8'h00, 8'h00, 0, 0, 0, 0, 0);
    step("R8 half lower", 1, 8'h0F, 8'h00, 8'h00, 8'h00, 2'b01, 8'hFF, 0, 0, 2'b01);
    step("R8 half upper", 1, 8'h0F, 8'h00, 8'h00, 8'h00, 2'b01, 8'hFF, 0, 0, 2'b10);
    step("R8 half none", 1, 8'h0F, 8'h00, 8'h00, 8'h00, 2'b01, 8'hFF, 0, 0, 2'b11);
    step("R8 half none", 1, 8'h0F, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0);
    step("R4 transient start", 1, 0, 8'hFF, 8'hFF, 8'hFF, 2'b10, 8'h02, 0, 3, 0);
    step("R4 transient 1", 1, 0, 8'hFF, 8'hFF, 8'hFF, 0, 0, 0, 0, 0);
    step("R5 retrigger ignored", 1, 0, 8'hFF, 8'hFF, 8'hFF, 2'b10, 8'h02, 0, 9, 0);
    step("R4 transient 3", 1, 0, 8'hFF, 8'hFF, 8'hFF, 0, 0, 0, 0, 0);
    step("R4 transient released", 1, 0, 8'hFF, 8'hFF, 8'hFF, 0, 0, 0, 0, 0);
    step("R4 transient released", 1, 0, 8'hFF, 8'h0F, 8'hFF, 0, 0, 0, 0, 0);
    step("R4 upper half", 1, 0, 8'hFF, 8'h0F, 8'hFF, 2'b10, 8'hFF, 0, 1, 2'b10);
    step("R4 upper half", 1, 0, 8'hFF, 8'h0F, 8'hFF, 0, 0, 0, 0, 0);
    step("R4 upper half", 1, 0, 8'hFF, 8'h0F, 8'hFF, 0, 0, 0, 0, 0);
    step("R6 zero length", 1, 0, 8'hFF, 8'hFF, 8'hFF, 2'b10, 8'hFF, 0, 0, 0);
    step("R6 zero length", 1, 0, 8'hFF, 8'hFF, 8'hFF, 0, 0, 0, 0, 0);
    step("R6 zero length", 1, 0, 8'hFF, 8'hFF, 8'hFF, 0, 0, 0, 0, 0);
    step("R7 stuck", 1, 0, 8'hFF, 8'hFF, 8'hFF, 2'b11, 8'h0C, 8'h04, 0, 0);
    step("R7 stuck held", 1, 0, 8'hFF, 8'h00, 8'h00, 2'b11, 8'h0C, 8'h08, 0, 0);
    step("R7 stuck released", 1, 0, 8'hFF, 8'h00, 8'h00, 0, 0, 8'hFF, 0, 0);
    step("R7 stuck lower only", 1, 0, 8'hFF, 8'h00, 8'h00, 2'b11, 8'hFF, 8'hFF, 0, 2'b01);
    step("R1 reset again", 0, 8'hFF, 8'hFF, 8'h00, 8'h00, 0, 0, 0, 0, 0);
    step("R2 after reset", 1, 8'h96, 8'hFF, 8'h3C, 8'h0F, 0, 0, 0, 0, 0);
    step("R2 after reset", 1, 8'h00, 8'h00, 8'h3C, 8'hF0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule